// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Access

This block supervises software by counting down from a programmed start value. Software must restart the count at regular intervals with a keyed command. If the count runs out, the block flags an underflow. If the restart comes too early, while the count is still above a programmed window threshold, it flags a window error. Either event can raise a one-cycle system reset request. A prescaler divides the clock by a power of two before it reaches the counter, so one setting covers a wide range of timeouts.

The configuration is the start value, the window threshold, the prescaler setting and the reset enable. A magic-value lock guards all of it against stray writes. The two status flags stay set until a reset or a write of one clears them. Counting can be frozen while the system sleeps or while a debugger halts the processor, and each of these freezes is chosen separately. The register port is a plain single-cycle write strobe with a combinational read mux. Everything runs on one clock.

Top module: `wdog_window`

## Requirements
- R1: After reset the start value and the window threshold are all ones (0xFFF), the prescaler setting, the reset enable, the lock state, both freeze selects and both flags are zero, and reads of address 2 return zero.
- R2: The prescaler setting P sits at address 1 bits [18:16] and divides the clock by 2^P (1 to 128). The counter decrements once per divided tick, and a restart clears the prescaler phase.
- R3: Writing 0x35CA to address 3 bits [15:0] unlocks the configuration; writing any other value locks it. Bit 0 read at address 3 is 1 while locked.
- R4: While locked, writes to address 0 (bits [11:0] start value, bit 16 reset enable) and to address 1 (bits [11:0] window threshold, prescaler) are ignored.
- R5: A write to address 2 with bit 0 set and bits [31:16] equal to 0x5FA0 loads the counter with the start value. The counter value is read at address 6 bits [11:0].
- R6: A write to address 2 with any other key, or with bit 0 clear, leaves the counter unchanged and raises no error.
- R7: A valid restart while the count is strictly greater than the window threshold sets the error flag (address 4 bit 1). The restart still takes place. A count equal to the threshold is accepted.
- R8: When the window threshold is greater than or equal to the start value, restarts are never flagged as early.
- R9: A tick that arrives while the count is zero sets the underflow flag (address 4 bit 0) and reloads the start value, so counting carries on.
- R10: An underflow or a window error drives the reset request high for exactly one cycle, starting at the clock edge that records the event, and only when the reset enable is set.
- R11: Writing 1 to a flag bit at address 4 clears that flag. Writing 0 to a flag bit leaves it unchanged.
- R12: With address 5 bit 0 set, counting halts while sleep is asserted. With address 5 bit 1 set, counting halts while debug is asserted. With a select clear, counting continues through that condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 32 | Read data (combinational) |
| sleep_i | input | 1 | System sleep indication |
| debug_i | input | 1 | Processor halted by debugger |
| wdt_rst_o | output | 1 | One-cycle system reset request |

## Verification
The restart command is tried with a correct key, with a key that differs in one bit, and with the request bit clear. This separates key matching from bit-0 decoding. The window check is driven with the count above, equal to and below the threshold, and once with the threshold above the start value, so the strict comparison and the self-disable can each be told apart. Runs of exact length with the counter unfrozen, at prescaler settings 0, 2 and 7, separate the tick period, the reload on underflow and the freeze selects. Each run is repeated with the reset enable on and off to separate flag setting from reset request generation.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef logic [2:0] reg_addr_t;

    localparam reg_addr_t A_CFG  = 3'd0;  // start value, reset enable
    localparam reg_addr_t A_WIN  = 3'd1;  // window threshold, prescaler
    localparam reg_addr_t A_CMD  = 3'd2;  // keyed restart
    localparam reg_addr_t A_LOCK = 3'd3;  // write lock
    localparam reg_addr_t A_STAT = 3'd4;  // sticky flags, write one to clear
    localparam reg_addr_t A_FRZ  = 3'd5;  // freeze selects
    localparam reg_addr_t A_CNT  = 3'd6;  // live count, read only
endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
    parameter int PS_W = 3
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            run_i,
    input  logic            restart_i,
    input  logic [PS_W-1:0] sel_i,
    output logic            tick_o
);
    localparam int DIV_W = (1 << PS_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } tick_st_t;

    tick_st_t s_d, s_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask   = ~({DIV_W{1'b1}} << sel_i);
        tick_o = run_i && ((s_q.phase & mask) == mask);
        s_d    = s_q;
        if (restart_i)  s_d.phase = '0;
        else if (run_i) s_d.phase = s_q.phase + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // With no division every running cycle is a tick
    p_undivided_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && sel_i == '0) |-> tick_o);
    // A frozen divider neither ticks nor advances
    p_frozen_phase_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !restart_i) |=> $stable(s_q.phase));
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] start_i,
    input  logic [CNT_W-1:0] delta_i,
    input  logic             rst_en_i,
    input  logic             clr_uf_i,
    input  logic             clr_err_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             uf_o,
    output logic             err_o,
    output logic             req_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             uf;
        logic             err;
        logic             req;
    } cnt_st_t;

    cnt_st_t s_d, s_q;
    logic win_on, early, uf_evt;

    always_comb begin
        win_on = delta_i < start_i;
        early  = reload_i && win_on && (s_q.cnt > delta_i);
        uf_evt = tick_i && !reload_i && (s_q.cnt == '0);

        s_d = s_q;
        if (reload_i)    s_d.cnt = start_i;
        else if (uf_evt) s_d.cnt = start_i;
        else if (tick_i) s_d.cnt = s_q.cnt - 1'b1;

        s_d.uf  = uf_evt | (s_q.uf  & ~clr_uf_i);
        s_d.err = early  | (s_q.err & ~clr_err_i);
        s_d.req = (uf_evt | early) & rst_en_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '{cnt: '1, uf: 1'b0, err: 1'b0, req: 1'b0};
        else         s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
    assign uf_o  = s_q.uf;
    assign err_o = s_q.err;
    assign req_o = s_q.req;

    // Underflow reloads the start value
    p_uf_reload_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !reload_i && s_q.cnt == '0) |=> (s_q.cnt == $past(start_i) && s_q.uf));
    // Early restart inside an active window raises the error flag
    p_early_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reload_i && delta_i < start_i && s_q.cnt > delta_i) |=> s_q.err);
    // A request needs the enable in the cycle of the event
    p_req_enabled_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rst_en_i |=> !s_q.req);
    // Without a tick or restart the count holds
    p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !reload_i) |=> $stable(s_q.cnt));
endmodule

// File: rtl/wdog_window.sv
module wdog_window #(
    parameter int          CNT_W      = 12,
    parameter int          PS_W       = 3,
    parameter logic [15:0] UNLOCK_KEY = 16'h35CA,
    parameter logic [15:0] RELOAD_KEY = 16'h5FA0
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_en_i,
    input  logic [2:0]  wr_addr_i,
    input  logic [31:0] wr_data_i,
    input  logic [2:0]  rd_addr_i,
    output logic [31:0] rd_data_o,
    input  logic        sleep_i,
    input  logic        debug_i,
    output logic        wdt_rst_o
);
    import wdog_pkg::*;

    localparam int SEL_LSB = 16;

    typedef struct packed {
        logic [CNT_W-1:0] start;
        logic [CNT_W-1:0] delta;
        logic [PS_W-1:0]  presc;
        logic             rst_en;
        logic             locked;
        logic             stop_sleep;
        logic             stop_dbg;
    } cfg_t;

    cfg_t c_d, c_q;
    logic             restart, run, tick, clr_uf, clr_err, uf, err;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        c_d = c_q;
        if (wr_en_i) begin
            case (wr_addr_i)
                A_CFG: if (!c_q.locked) begin
                    c_d.start  = wr_data_i[CNT_W-1:0];
                    c_d.rst_en = wr_data_i[SEL_LSB];
                end
                A_WIN: if (!c_q.locked) begin
                    c_d.delta = wr_data_i[CNT_W-1:0];
                    c_d.presc = wr_data_i[SEL_LSB +: PS_W];
                end
                A_LOCK: c_d.locked = (wr_data_i[15:0] != UNLOCK_KEY);
                A_FRZ: begin
                    c_d.stop_sleep = wr_data_i[0];
                    c_d.stop_dbg   = wr_data_i[1];
                end
                default: ;
            endcase
        end
        restart = wr_en_i && (wr_addr_i == A_CMD) && wr_data_i[0]
                  && (wr_data_i[31:16] == RELOAD_KEY);
        clr_uf  = wr_en_i && (wr_addr_i == A_STAT) && wr_data_i[0];
        clr_err = wr_en_i && (wr_addr_i == A_STAT) && wr_data_i[1];
        run     = !(sleep_i && c_q.stop_sleep) && !(debug_i && c_q.stop_dbg);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '{start: '1, delta: '1, presc: '0, rst_en: 1'b0,
                              locked: 1'b0, stop_sleep: 1'b0, stop_dbg: 1'b0};
        else         c_q <= c_d;
    end

    wdog_tick #(.PS_W(PS_W)) u_tick (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run),
        .restart_i (restart),
        .sel_i     (c_q.presc),
        .tick_o    (tick)
    );

    wdog_count #(.CNT_W(CNT_W)) u_count (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick),
        .reload_i  (restart),
        .start_i   (c_q.start),
        .delta_i   (c_q.delta),
        .rst_en_i  (c_q.rst_en),
        .clr_uf_i  (clr_uf),
        .clr_err_i (clr_err),
        .cnt_o     (cnt),
        .uf_o      (uf),
        .err_o     (err),
        .req_o     (wdt_rst_o)
    );

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            A_CFG: begin
                rd_data_o[CNT_W-1:0] = c_q.start;
                rd_data_o[SEL_LSB]   = c_q.rst_en;
            end
            A_WIN: begin
                rd_data_o[CNT_W-1:0]         = c_q.delta;
                rd_data_o[SEL_LSB +: PS_W]   = c_q.presc;
            end
            A_LOCK: rd_data_o[0] = c_q.locked;
            A_STAT: rd_data_o[1:0] = {err, uf};
            A_FRZ:  rd_data_o[1:0] = {c_q.stop_dbg, c_q.stop_sleep};
            A_CNT:  rd_data_o[CNT_W-1:0] = cnt;
            default: ;
        endcase
    end

    // Locked configuration cannot change through a write
    p_locked_cfg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (c_q.locked && wr_en_i && (wr_addr_i == A_CFG || wr_addr_i == A_WIN))
        |=> ($stable(c_q.start) && $stable(c_q.delta) && $stable(c_q.presc) && $stable(c_q.rst_en)));
    // Reset request lasts one cycle when events are spaced
    p_req_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(wdt_rst_o) && !restart) |=> (!wdt_rst_o || $past(tick)));
endmodule

// File: tb/wdog_window_bench.sv
module wdog_window_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        sleep = 1'b0;
    logic        debug = 1'b0;
    logic        wdt_rst;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;

    typedef struct {
        logic [2:0]  a;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];
    event  sb_ev;

    localparam logic [2:0] CFG = 3'd0, WIN = 3'd1, CMD = 3'd2, LCK = 3'd3,
                           STA = 3'd4, FRZ = 3'd5, CNT = 3'd6;
    localparam logic [31:0] GO = 32'h5FA0_0001;

    always #2.5 clk = ~clk;  // 200 MHz

    wdog_window u_wdog_window (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .sleep_i(sleep), .debug_i(debug), .wdt_rst_o(wdt_rst)
    );

    always @(negedge clk) if (rst_n && wdt_rst) pulses++;

    // Monitor: pops expected items and compares with the read port
    initial forever begin
        @(sb_ev);
        #1;
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (rd_data !== it.exp) begin
                fails++;
                $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.a, rd_data, it.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        item_t it;
        rd_addr = a;
        it.a = a; it.exp = e; it.tag = tag;
        sb.push_back(it);
        -> sb_ev;
        #2;
    endtask

    task automatic expect_pulses(input int e, input string tag);
        checks++;
        if (pulses != e) begin
            fails++;
            $display("FAIL %s pulses actual=%0d expected=%0d", tag, pulses, e);
        end
    endtask

    task automatic run_tests;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_rd(CFG, 32'h0000_0FFF, "R1 start");
        expect_rd(WIN, 32'h0000_0FFF, "R1 window");
        expect_rd(LCK, 32'h0, "R1 lock");
        expect_rd(STA, 32'h0, "R1 flags");
        expect_rd(FRZ, 32'h0, "R1 freeze");
        expect_rd(CMD, 32'h0, "R1 cmd reads zero");

        sleep = 1'b1;
        wr(FRZ, 32'h1);                      // halt while asleep
        wr(CFG, 32'h0001_0010);
        wr(WIN, 32'h0000_0FFF);
        wr(CMD, GO);
        expect_rd(CNT, 32'h010, "R5 restart loads start");
        expect_rd(STA, 32'h0, "R8 no error with wide window");

        wr(CFG, 32'h0001_0020);
        wr(CMD, 32'h5FA1_0001);
        expect_rd(CNT, 32'h010, "R6 wrong key ignored");
        wr(CMD, 32'h5FA0_0000);
        expect_rd(CNT, 32'h010, "R6 request bit clear ignored");
        expect_rd(STA, 32'h0, "R6 no error from ignored command");
        wr(CMD, GO);
        expect_rd(CNT, 32'h020, "R5 restart with new start");

        wr(WIN, 32'h0000_0008);
        wr(CMD, GO);                         // count 0x20 > 8: early
        expect_rd(STA, 32'h2, "R7 early restart flagged");
        expect_rd(CNT, 32'h020, "R7 restart still applied");
        expect_pulses(1, "R10 request on error");
        wr(STA, 32'h1);
        expect_rd(STA, 32'h2, "R11 other flag untouched");
        wr(STA, 32'h2);
        expect_rd(STA, 32'h0, "R11 error flag cleared");

        wr(CFG, 32'h0001_0005);
        wr(CMD, GO);                         // threshold 8 >= start 5
        expect_rd(STA, 32'h0, "R8 window disabled");
        expect_rd(CNT, 32'h005, "R5 count after restart");
        wr(CFG, 32'h0001_0020);
        wr(CMD, GO);                         // count 5 below threshold
        expect_rd(STA, 32'h0, "R7 restart inside window");
        wr(CFG, 32'h0001_0008);
        wr(CMD, GO);
        wr(CFG, 32'h0001_0020);
        wr(CMD, GO);                         // count equals threshold
        expect_rd(STA, 32'h0, "R7 count equal to threshold accepted");
        expect_pulses(1, "R10 no extra request");

        wr(LCK, 32'h0000_1234);
        expect_rd(LCK, 32'h1, "R3 locked");
        wr(CFG, 32'h0000_00AA);
        expect_rd(CFG, 32'h0001_0020, "R4 start write ignored");
        wr(WIN, 32'h0007_0000);
        expect_rd(WIN, 32'h0000_0008, "R4 window write ignored");
        wr(LCK, 32'h0000_35CA);
        expect_rd(LCK, 32'h0, "R3 unlocked");
        wr(LCK, 32'h0000_35CB);
        expect_rd(LCK, 32'h1, "R3 near key locks");
        wr(LCK, 32'h0000_35CA);

        // Underflow with reset enable
        wr(CFG, 32'h0001_0003);
        wr(WIN, 32'h0000_0FFF);
        wr(CMD, GO);
        sleep = 1'b0;
        repeat (6) @(negedge clk);
        sleep = 1'b1;
        expect_rd(CNT, 32'h001, "R9 counting resumes after reload");
        expect_rd(STA, 32'h1, "R9 underflow flagged");
        expect_pulses(2, "R10 request on underflow");
        wr(STA, 32'h1);
        expect_rd(STA, 32'h0, "R11 underflow flag cleared");

        // Underflow without reset enable
        wr(CFG, 32'h0000_0003);
        wr(CMD, GO);
        sleep = 1'b0;
        repeat (6) @(negedge clk);
        sleep = 1'b1;
        expect_rd(CNT, 32'h001, "R9 second underflow");
        expect_rd(STA, 32'h1, "R9 flag without enable");
        expect_pulses(2, "R10 no request when disabled");
        wr(STA, 32'h3);

        // Debug freeze, sleep no longer halts, divide by 4
        debug = 1'b1;
        wr(FRZ, 32'h2);
        wr(WIN, 32'h0002_0FFF);
        wr(CMD, GO);
        debug = 1'b0;
        repeat (8) @(negedge clk);
        debug = 1'b1;
        expect_rd(CNT, 32'h001, "R2 R12 divide by four while asleep");
        repeat (10) @(negedge clk);
        expect_rd(CNT, 32'h001, "R12 debug halt holds count");

        // Largest division
        wr(CFG, 32'h0000_0001);
        wr(WIN, 32'h0007_0FFF);
        wr(CMD, GO);
        debug = 1'b0;
        repeat (127) @(negedge clk);
        debug = 1'b1;
        expect_rd(CNT, 32'h001, "R2 no tick before 128 cycles");
        debug = 1'b0;
        @(negedge clk);
        debug = 1'b1;
        expect_rd(CNT, 32'h000, "R2 tick at 128 cycles");
        #5;
    endtask

    initial begin
        fork
            run_tests();
            begin
                #1000000;
                fails++;
                $display("FAIL watchdog all requirements actual=timeout expected=completion");
            end
        join_any
        disable fork;
        #5;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule